// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Tag Controller

This block holds the tag and line-state storage for a direct-mapped second-level cache. For each memory access it decides, within one clock, whether the line currently held at the addressed index belongs to the requested address. On a miss it allocates the line immediately: it writes the new tag, sets the line valid, and marks it dirty only for a write. It also reports any dirty line that the miss pushes out. The data array, the bus protocol and the movement of write-back data are handled elsewhere. This block supplies only the decision, the tag value written to the external tag store, and the address of an evicted dirty line.

Three static configuration pins set the geometry:
- `cfg_big` selects the larger cache (one more index bit) or the smaller one.
- `cfg_tag10` selects a 10-bit or an 8-bit external tag.
- `cfg_dtag` reserves the top external tag bit for the dirty flag.

The per-line state RAM has a fixed number of bits. In the larger cache it holds two bits per line: valid and dirty. In the smaller cache it holds four bits per line, and two of them serve as extra tag bits above the external tag. This widens the cacheable range by a factor of four. Any address at or beyond the cacheable limit is reported as uncached and leaves the storage untouched.

The request side is a valid/ready input. `req_ready` stays low while the post-reset sweep clears every valid bit, and stays high afterwards, so a request is never held off once the sweep is done. The response is a fixed-latency pulse one cycle after acceptance. It has no back-pressure: the consumer must take it in that cycle. The configuration pins may only change while reset is held. The default parameters give a scaled geometry (64 or 128 lines). A full-size instance uses `IDX_W = 13`, which gives 8K or 16K lines of 32 bytes.

Top module: `l2t_ctrl`

## Requirements
- R1: After `rst_n` is released, `req_ready` is low for exactly 2^IDX_W clock cycles while the state RAM is cleared, then stays high. Every line is invalid afterwards, so the first access to any address misses, even if that address was resident before the reset.
- R2: The byte offset is address bits [4:0]. The line index is the next IDX_W bits (smaller cache) or IDX_W+1 bits (larger cache). Everything above the index is the address tag.
- R3: A cacheable access hits only when the indexed line is valid and its stored tag equals the address tag. Otherwise it misses. Exactly one of `rsp_hit` and `rsp_miss` is set on a cacheable response.
- R4: The number of cacheable address bits is 5 + index bits + E, plus 2 in the smaller cache, where E is 10 or 8 and is reduced by 1 when `cfg_dtag` is set. An address with any bit set at or above that position gives `rsp_uncached`=1, `rsp_hit`=0, `rsp_miss`=0 and `victim_dirty`=0, and changes no stored line.
- R5: In the smaller cache, the two address-tag bits just above the E external bits are kept in the state RAM. Two addresses that differ only in those bits replace each other.
- R6: A miss allocates the line, so that a following access to the same line hits. The new line is dirty only if the miss was a write.
- R7: A write hit marks the line dirty. A read hit leaves the dirty state unchanged.
- R8: A miss that replaces a valid dirty line pulses `victim_dirty` together with `victim_addr`. `victim_addr` is the replaced line's address with offset bits zero. Replacing a clean or invalid line leaves `victim_dirty` low.
- R9: `rsp_fill_tag` shows the value written to the external tag store by the access. On a miss it is the low E bits of the address tag; when `cfg_dtag` is set, bit E carries the new dirty flag. A write hit with `cfg_dtag` set rewrites the tag with bit E set. Every other access shows 0.
- R10: A request is accepted on a rising edge with `req_valid` and `req_ready` both high. Its result appears with `rsp_valid`=1 in the following cycle. Back-to-back requests are accepted every cycle, and each one sees the updates made by the one before. Without an accepted request, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the clearing sweep |
| cfg_big | input | 1 | 1 = larger cache (IDX_W+1 index bits), 0 = smaller cache |
| cfg_tag10 | input | 1 | 1 = 10-bit external tag, 0 = 8-bit |
| cfg_dtag | input | 1 | 1 = top external tag bit holds the dirty flag |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept a request (sweep finished) |
| req_addr | input | ADDR_W | Physical byte address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Result of the access accepted on the previous edge |
| rsp_hit | output | 1 | Line present |
| rsp_miss | output | 1 | Line absent and now allocated |
| rsp_uncached | output | 1 | Address beyond the cacheable limit |
| rsp_fill_tag | output | 10 | Value written to the external tag store, or 0 |
| victim_dirty | output | 1 | Replaced line was valid and dirty |
| victim_addr | output | ADDR_W | Line address of the dirty victim |

## Verification
Because the state and tag stores are internal, corrupted line state shows at the ports only on the next access to the same index. A lost valid bit turns an expected hit into a miss. A lost dirty bit removes a `victim_dirty` pulse, and a wrong extra tag bit gives a false hit or a wrong `victim_addr`. The random traffic is therefore confined to a handful of indices and tags, so that every line is revisited within a few accesses. A wrong cacheable limit or a wrong field split shows in the very response of the boundary address, and a stalled or shortened sweep shows in the cycle count to `req_ready`.

// File: rtl/l2t_pkg.sv
package l2t_pkg;
  localparam int OFF_W     = 5;
  localparam int EXT_MAX_W = 10;
  localparam int XTAG_W    = 2;

  typedef struct packed {
    logic [XTAG_W-1:0] xtag;
    logic              dirty;
    logic              valid;
  } line_state_t;
endpackage

// File: rtl/l2t_geom.sv
module l2t_geom
  import l2t_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 6
) (
  input  logic                 cfg_big,
  input  logic                 cfg_tag10,
  input  logic                 cfg_dtag,
  input  logic [ADDR_W-1:0]    addr,
  output logic [IDX_W:0]       idx,
  output logic [7:0]           lo,
  output logic [7:0]           eff,
  output logic [EXT_MAX_W-1:0] ext_mask,
  output logic [EXT_MAX_W-1:0] atag_ext,
  output logic [XTAG_W-1:0]    atag_x,
  output logic                 cacheable
);
  logic [7:0]        span;
  logic [ADDR_W-1:0] tagf;

  always_comb begin
    lo   = 8'(OFF_W + IDX_W) + {7'd0, cfg_big};
    eff  = (cfg_tag10 ? 8'd10 : 8'd8) - {7'd0, cfg_dtag};
    span = lo + eff + (cfg_big ? 8'd0 : 8'(XTAG_W));
    idx  = addr[OFF_W +: IDX_W+1];
    if (!cfg_big) idx[IDX_W] = 1'b0;
    tagf      = addr >> lo;
    ext_mask  = ~({EXT_MAX_W{1'b1}} << eff);
    atag_ext  = tagf[EXT_MAX_W-1:0] & ext_mask;
    atag_x    = cfg_big ? '0 : XTAG_W'(tagf >> eff);
    cacheable = (addr >> span) == '0;
  end
endmodule

// File: rtl/l2t_state_ram.sv
module l2t_state_ram
  import l2t_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_big,
  input  logic [IDX_W:0] idx,
  input  logic        wr_en,
  input  line_state_t wr_state,
  output line_state_t rd_state,
  output logic        sweep_done
);
  localparam int WORDS = 2**IDX_W;

  logic [3:0]       mem [WORDS];
  logic [IDX_W-1:0] sweep_cnt;
  logic [IDX_W-1:0] widx;
  logic             half;
  logic [3:0]       word;

  always_comb begin
    widx = cfg_big ? idx[IDX_W:1] : idx[IDX_W-1:0];
    half = cfg_big & idx[0];
    word = mem[widx];
    if (cfg_big) begin
      rd_state.valid = half ? word[2] : word[0];
      rd_state.dirty = half ? word[3] : word[1];
      rd_state.xtag  = '0;
    end else begin
      rd_state.valid = word[0];
      rd_state.dirty = word[1];
      rd_state.xtag  = word[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep_cnt  <= '0;
      sweep_done <= 1'b0;
    end else if (!sweep_done) begin
      sweep_cnt <= sweep_cnt + 1'b1;
      if (sweep_cnt == '1) sweep_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!sweep_done) begin
      mem[sweep_cnt] <= '0;
    end else if (wr_en) begin
      if (!cfg_big)  mem[widx]      <= {wr_state.xtag, wr_state.dirty, wr_state.valid};
      else if (half) mem[widx][3:2] <= {wr_state.dirty, wr_state.valid};
      else           mem[widx][1:0] <= {wr_state.dirty, wr_state.valid};
    end
  end

  // R1
  no_write_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sweep_done |-> !wr_en);
endmodule

// File: rtl/l2t_tag_ram.sv
module l2t_tag_ram
  import l2t_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic [IDX_W:0]       idx,
  input  logic                 we,
  input  logic [EXT_MAX_W-1:0] wdata,
  output logic [EXT_MAX_W-1:0] rdata
);
  localparam int DEPTH = 2**(IDX_W+1);

  logic [EXT_MAX_W-1:0] mem [DEPTH];

  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end
endmodule

// File: rtl/l2t_ctrl.sv
module l2t_ctrl
  import l2t_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_big,
  input  logic                 cfg_tag10,
  input  logic                 cfg_dtag,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_uncached,
  output logic [EXT_MAX_W-1:0] rsp_fill_tag,
  output logic                 victim_dirty,
  output logic [ADDR_W-1:0]    victim_addr
);
  logic [IDX_W:0]       idx;
  logic [7:0]           lo, eff;
  logic [EXT_MAX_W-1:0] ext_mask, atag_ext, tag_rd, tag_wd;
  logic [XTAG_W-1:0]    atag_x;
  logic                 cacheable, sweep_done;
  line_state_t          st_rd, st_wd;
  logic                 acc, hit, miss, line_dirty, new_dirty, tag_match;
  logic                 tag_we, st_we, victim;
  logic [ADDR_W-1:0]    old_tag, vaddr;

  l2t_geom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_geom (
    .cfg_big(cfg_big), .cfg_tag10(cfg_tag10), .cfg_dtag(cfg_dtag), .addr(req_addr),
    .idx(idx), .lo(lo), .eff(eff), .ext_mask(ext_mask), .atag_ext(atag_ext),
    .atag_x(atag_x), .cacheable(cacheable)
  );

  l2t_state_ram #(.IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .idx(idx), .wr_en(st_we),
    .wr_state(st_wd), .rd_state(st_rd), .sweep_done(sweep_done)
  );

  l2t_tag_ram #(.IDX_W(IDX_W)) u_tag (
    .clk(clk), .idx(idx), .we(tag_we), .wdata(tag_wd), .rdata(tag_rd)
  );

  assign req_ready = sweep_done;

  always_comb begin
    acc        = req_valid && req_ready;
    line_dirty = cfg_dtag ? ((tag_rd >> eff) & EXT_MAX_W'(1)) != '0 : st_rd.dirty;
    tag_match  = ((tag_rd & ext_mask) == atag_ext) && (cfg_big || st_rd.xtag == atag_x);
    hit        = cacheable && st_rd.valid && tag_match;
    miss       = cacheable && !hit;
    new_dirty  = hit ? (line_dirty | req_write) : req_write;
    tag_we     = acc && (miss || (hit && req_write && cfg_dtag));
    st_we      = acc && (miss || (hit && req_write));
    tag_wd     = atag_ext | ((cfg_dtag && new_dirty) ? (EXT_MAX_W'(1) << eff) : '0);
    st_wd.valid = 1'b1;
    st_wd.dirty = new_dirty && !cfg_dtag;
    st_wd.xtag  = atag_x;
    victim     = miss && st_rd.valid && line_dirty;
    old_tag    = ADDR_W'(tag_rd & ext_mask) | (ADDR_W'(st_rd.xtag) << eff);
    vaddr      = (old_tag << lo) | (ADDR_W'(idx) << OFF_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_uncached <= 1'b0;
      rsp_fill_tag <= '0;
      victim_dirty <= 1'b0;
      victim_addr  <= '0;
    end else begin
      rsp_valid    <= acc;
      rsp_hit      <= acc && hit;
      rsp_miss     <= acc && miss;
      rsp_uncached <= acc && !cacheable;
      rsp_fill_tag <= tag_we ? tag_wd : '0;
      victim_dirty <= acc && victim;
      victim_addr  <= (acc && victim) ? vaddr : '0;
    end
  end

  // R10
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));
  // R4
  uncached_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncached) |-> (!rsp_hit && !rsp_miss && !victim_dirty));
  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_uncached) |-> (rsp_hit ^ rsp_miss));
  // R8
  victim_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_dirty |-> rsp_miss);
endmodule

// File: tb/l2t_ctrl_test.sv
module l2t_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 6;
  localparam int NL     = 2**(IDX_W+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_big = 1'b0, cfg_tag10 = 1'b1, cfg_dtag = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss, rsp_uncached, victim_dirty;
  logic [9:0] rsp_fill_tag;
  logic [ADDR_W-1:0] victim_addr;

  int nchk = 0, nfail = 0;
  bit ref_v [NL];
  bit ref_d [NL];
  int unsigned ref_t [NL];
  int lo, eff, tw, span;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2t_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_big(cfg_big), .cfg_tag10(cfg_tag10), .cfg_dtag(cfg_dtag),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_uncached(rsp_uncached),
    .rsp_fill_tag(rsp_fill_tag), .victim_dirty(victim_dirty), .victim_addr(victim_addr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic int unsigned mk(input int unsigned tag, input int unsigned idx);
    return (tag << lo) | (idx << 5);
  endfunction

  task automatic do_reset();
    int cyc;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < NL; i++) begin ref_v[i] = 0; ref_d[i] = 0; ref_t[i] = 0; end
    repeat (2) @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk(req_ready == 1'b0, "R1", "ready in reset", 32'(req_ready), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!req_ready && cyc < 1000) begin @(posedge clk); #1; cyc++; end
    chk(cyc == 2**IDX_W, "R1", "sweep length", 32'(cyc), 32'(2**IDX_W));
  endtask

  task automatic do_acc(input int unsigned a, input bit wr, input string rq);
    int unsigned idx, tagf, vexp, fexp;
    bit cach, hit, vic, newd;
    idx  = (a >> 5) & (cfg_big ? NL-1 : NL/2-1);
    tagf = a >> lo;
    cach = (a >> span) == 0;
    hit  = cach && ref_v[idx] && ref_t[idx] == tagf;
    vic  = cach && !hit && ref_v[idx] && ref_d[idx];
    vexp = vic ? mk(ref_t[idx], idx) : 0;
    newd = hit ? (ref_d[idx] | wr) : wr;
    fexp = 0;
    if (cach && (!hit || (wr && cfg_dtag)))
      fexp = (tagf & ((1 << eff) - 1)) | ((cfg_dtag && newd) ? (1 << eff) : 0);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a[ADDR_W-1:0];
    req_write = wr;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b1, "R10", "rsp_valid", 32'(rsp_valid), 1);
    chk(rsp_uncached == !cach, "R4", "uncached", 32'(rsp_uncached), 32'(!cach));
    chk(rsp_hit == hit && rsp_miss == (cach && !hit), rq, "hit/miss",
        {rsp_hit, rsp_miss}, {hit, cach && !hit});
    chk(victim_dirty == vic && victim_addr == vexp[ADDR_W-1:0], "R8", "victim",
        {victim_dirty, 7'd0, victim_addr}, {vic, 7'd0, vexp[ADDR_W-1:0]});
    chk(rsp_fill_tag == fexp[9:0], "R9", "fill tag", 32'(rsp_fill_tag), fexp);
    if (cach && (!hit || wr)) begin
      ref_v[idx] = 1; ref_d[idx] = newd; ref_t[idx] = tagf;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R10", "no request", 32'(rsp_valid), 0);
  endtask

  task automatic run_cfg(input bit big, input bit t10, input bit dt);
    int unsigned t, ix, off;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_big = big; cfg_tag10 = t10; cfg_dtag = dt;
    lo   = 5 + IDX_W + (big ? 1 : 0);
    eff  = (t10 ? 10 : 8) - (dt ? 1 : 0);
    tw   = eff + (big ? 0 : 2);
    span = lo + tw;
    do_reset();
    // R1 / R6: cold miss after the sweep, then allocation gives a hit
    do_acc(mk(5, 3), 0, "R1");
    do_acc(mk(5, 3), 0, "R6");
    // R7: write hit marks dirty
    do_acc(mk(5, 3), 1, "R7");
    // R8: conflicting tag evicts the dirty line
    do_acc(mk(6, 3), 0, "R8");
    do_acc(mk(6, 3), 0, "R3");
    do_acc(mk(5, 3), 0, "R8");
    // R6: write miss allocates dirty
    do_acc(mk(7, 9), 1, "R6");
    do_acc(mk(2, 9), 0, "R8");
    // R4: limit boundary, and an uncached access leaves the line alone
    do_acc((1 << span) - 32, 0, "R4");
    do_acc((1 << span) | mk(0, 3), 1, "R4");
    do_acc(mk(5, 3), 0, "R4");
    // R5: addresses differing only above the external tag bits
    do_acc(mk(1, 12), 0, "R5");
    do_acc(mk(1 | (1 << eff), 12), 0, "R5");
    do_acc(mk(1, 12), 0, "R5");
    // R2: index wraps at the index width
    do_acc(mk(3, (big ? NL : NL/2) - 1), 0, "R2");
    do_acc(mk(3, (big ? NL : NL/2) - 1) + 31, 0, "R2");
    idle();
    for (int n = 0; n < 300; n++) begin
      case ($urandom % 6)
        0: t = 0;
        1: t = 1;
        2: t = (1 << (tw - 2)) - 1;
        3: t = 1 << (tw - 1);
        4: t = (1 << tw) - 1;
        default: t = $urandom % (1 << tw);
      endcase
      if ($urandom % 8 == 0) t = t | (1 << tw);
      ix  = ($urandom % 4 < 3) ? ($urandom % 4) : ($urandom % (big ? NL : NL/2));
      off = $urandom % 32;
      do_acc(mk(t, ix) + off, 1'($urandom % 2), "R3");
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    run_cfg(0, 1, 0);
    run_cfg(1, 1, 0);
    run_cfg(0, 0, 1);
    run_cfg(1, 0, 1);
    run_cfg(0, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule